// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two W-bit operands over W clock cycles and leaves the 2W-bit product in a pair of W-bit registers: `hi` holds the upper half and `lo` the lower half. A single datapath serves both unsigned and two's-complement operands. A mode input, captured when the operation is accepted, chooses between them.

A caller pulses `start` with the operands and the mode while the unit is idle. `busy` then stays high for exactly W cycles. In each of those cycles one multiplier bit is consumed, starting from the least significant bit. When that bit is set, the multiplicand is added into the upper half of the partial product. The sum then lands one position to the right in the same register write, so no separate shift phase exists. The bit that falls off the bottom of `hi` enters the top of `lo`.

In unsigned mode the carry of the add fills the vacated top bit. In signed mode the sign of the widened sum fills that bit instead, and the final multiplier bit, which carries negative weight, causes a subtraction. `done` pulses for one cycle when the product is ready. The result is then held until the next accepted start.

Top module: `seq_shift_add_mul`

## Requirements
- R1: After reset, `busy`, `done`, `hi` and `lo` are all 0.
- R2: A `start` sampled high while `busy` is low makes `busy` high from the next cycle, for exactly W consecutive cycles.
- R3: `done` is high for exactly one cycle, the cycle right after the last busy cycle, and is never high together with `busy`.
- R4: With `is_signed` = 0, `{hi, lo}` at `done` equals the unsigned product of `mcand` and `mplier` as captured at the accepted start.
- R5: With `is_signed` = 1, `{hi, lo}` at `done` equals the 2W-bit two's-complement product, including operands equal to the most negative value (bit W-1 set, all other bits 0).
- R6: A `start` pulse while `busy` is high has no effect: the run in progress keeps its timing and its operands.
- R7: While idle with `start` low, `hi` and `lo` keep their values.
- R8: A `start` given in the same cycle that `done` is high is accepted, and a new run begins from the next cycle.
- R9: In unsigned mode, an add that carries out of W bits delivers that carry into the top bit of `hi`. Both operands set to all ones give {W-1 ones, a single 0, W-1 zeros, a single 1}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; accepted only when idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier |
| busy | output | 1 | High during the W iteration cycles |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | W | Upper half of the product |
| lo | output | W | Lower half of the product |

## Verification
Two situations are the hardest to reach from the ports. One is a start arriving in the exact cycle that `done` is high. The other is a start arriving while a run is under way. The stimulus watches `done` at the falling edge and raises `start` at once to reach the first. It drops a start with different operands into the middle of a run to reach the second. The signed sign-fill and the final subtraction only show up with negative multipliers and the most negative value, so those operands are driven on purpose beside a mixed unsigned and signed sweep.

// File: rtl/seq_shift_add_mul.sv
module seq_shift_add_mul #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  x_q, y_q;
  logic [CW-1:0] cnt;
  logic          sgn_q;

  logic          last;
  logic [W:0]    hi_ext, add_ext, sum;

  assign last    = (cnt == CW'(1));
  assign hi_ext  = {sgn_q & hi[W-1], hi};
  assign add_ext = y_q[0] ? {sgn_q & x_q[W-1], x_q} : '0;
  assign sum     = (sgn_q && last) ? hi_ext - add_ext : hi_ext + add_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      cnt   <= '0;
      sgn_q <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      hi    <= '0;
      lo    <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        hi  <= sum[W:1];
        lo  <= {sum[0], lo[W-1:1]};
        y_q <= y_q >> 1;
        cnt <= cnt - CW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        x_q   <= mcand;
        y_q   <= mplier;
        sgn_q <= is_signed;
        cnt   <= CW'(W);
        hi    <= '0;
        lo    <= '0;
        busy  <= 1'b1;
      end
    end
  end

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r2_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0));
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r3_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hi) && $stable(lo)));
  a_r6_busy_keeps_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> ($stable(x_q) && $stable(sgn_q) && busy));
endmodule

// File: tb/seq_shift_add_mul_tb.sv
module seq_shift_add_mul_tb;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic is_signed = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [W-1:0] hi, lo;

  int checks = 0, failures = 0, cycles = 0;
  string cur_tag = "R4";

  bit      m_busy = 0, m_done = 0;
  int      m_cnt = 0;
  logic [2*W-1:0] m_prod = '0;
  string   m_tag = "R1";

  seq_shift_add_mul #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .mcand(mcand), .mplier(mplier), .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_prod = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          m_done = 1;
        end
      end else if (start) begin
        longint a, b, p;
        a = is_signed ? longint'($signed(mcand)) : longint'(mcand);
        b = is_signed ? longint'($signed(mplier)) : longint'(mplier);
        p = a * b;
        m_prod = p[2*W-1:0];
        m_tag = cur_tag;
        m_busy = 1;
        m_cnt = W;
      end
    end
  end

  task automatic check(string tag, string what, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      check("R2", "busy", 16'(busy), 16'(m_busy));
      check("R3", "done", 16'(done), 16'(m_done));
      if (!m_busy) check(m_done ? m_tag : "R7", "product", {hi, lo}, m_prod);
    end
  end

  task automatic run(bit s, logic [W-1:0] a, logic [W-1:0] b, string tag);
    @(negedge clk);
    cur_tag = tag; is_signed = s; mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 2) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1", "reset", {14'd0, busy, done}, 16'd0);
    check("R1", "reset hi/lo", {hi, lo}, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(0, 8'd10, 8'd3, "R4");
    run(0, 8'd201, 8'd77, "R4");
    run(0, 8'hFF, 8'hFF, "R9");
    run(0, 8'h80, 8'hFF, "R9");
    run(1, 8'hF6, 8'd3, "R5");
    run(1, 8'hF6, 8'hFB, "R5");
    run(1, 8'h80, 8'h80, "R5");
    run(1, 8'h7F, 8'h80, "R5");
    run(1, 8'h80, 8'hFF, "R5");
    for (int i = 0; i < 40; i++)
      run(i[0], 8'(i * 37 + 5), 8'(i * 91 + 200), i[0] ? "R5" : "R4");

    @(negedge clk);
    cur_tag = "R6"; is_signed = 0; mcand = 8'd13; mplier = 8'd11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    cur_tag = "R6"; is_signed = 1; mcand = 8'h99; mplier = 8'h88; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 3) @(negedge clk);

    repeat (5) @(negedge clk);
    cur_tag = "R8"; is_signed = 0; mcand = 8'd250; mplier = 8'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    cur_tag = "R8"; is_signed = 1; mcand = 8'hC3; mplier = 8'h5A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8", "busy after done-cycle start", 16'(busy), 16'd1);
    repeat (W + 3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule